// File: doc/BRIEF.md
# Gate Driver Fault Supervisor

This block watches over a half-bridge gate driver. It tracks three fault conditions: supply undervoltage with hysteresis, over-temperature with separate trip and clear flags, and a startup overvoltage on the switch node. Every analog comparator is modelled as a digital input flag. The block reports any internal fault by requesting a pull-down on a shared open-drain enable line.

The same enable line is sensed back. A peer device that holds the line low therefore disables this driver as well, so one channel's fault can stop its neighbours. The sensed level first passes through a synchronizer and a debouncer. A power-on reset input models a power cycle.

The undervoltage and thermal faults force both gates off and recover on their own once the condition clears. The startup overvoltage fault is latched and forces the low-side gate on to discharge the output. Only a power cycle clears it.

Top module: `gate_fault_supervisor`

## Requirements
- R1: While `rst_n` is low and right after it is released, the block is in supply lockout: `fault_code` = 2'b01, `en_pull_low` = 1, `gates_off` = 1, `low_force_on` = 0.
- R2: The lockout stays while `vcc_start_ok` is low. One clock after `vcc_start_ok` is sampled high, the lockout clears.
- R3: Once the lockout has cleared, a low `vcc_start_ok` alone has no effect. If `vcc_hold_ok` is sampled low, the lockout returns on the next clock. It then stays until `vcc_start_ok` is sampled high again.
- R4: `temp_trip` sampled high sets the thermal fault one clock later. The fault stays until `temp_clear` is sampled high while `temp_trip` is low.
- R5: `ss_armed` and `sw_over` sampled high in the same cycle set the overvoltage fault one clock later. Neither flag alone sets it. Once set, it drives `low_force_on` = 1 whatever the other inputs do, and only `rst_n` low clears it.
- R6: `en_pull_low` is 1 exactly when an internal fault is active, that is, when `fault_code` is not 2'b00.
- R7: `fault_code` reports the highest-priority active fault: 2'b11 overvoltage, then 2'b10 thermal, then 2'b01 supply lockout, else 2'b00.
- R8: `gates_off` = (lockout or thermal or external disable) and not overvoltage. `gates_off` and `low_force_on` are never both 1.
- R9: An external disable takes effect after 3 consecutive synchronized low samples of `en_sense`, within 6 clocks of the change. It ends after 3 consecutive high samples. A low run of 2 cycles or fewer is ignored.
- R10: An external disable leaves `en_pull_low` and `fault_code` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset (models a power cycle) |
| vcc_start_ok | input | 1 | Supply above start threshold |
| vcc_hold_ok | input | 1 | Supply above release threshold |
| temp_trip | input | 1 | Die temperature above trip point |
| temp_clear | input | 1 | Die temperature below recovery point |
| ss_armed | input | 1 | Soft-start ramp past its monitoring point |
| sw_over | input | 1 | Switch node above startup limit |
| en_sense | input | 1 | Sensed level of the shared enable line |
| en_pull_low | output | 1 | Open-drain pull-down request on the enable line |
| gates_off | output | 1 | Force both gates off |
| low_force_on | output | 1 | Force low-side gate on for discharge |
| fault_code | output | 2 | Active fault code (see R7) |

## Verification
The bench aims at the hysteresis window, where only the release flag is high. A design that compared against the start flag alone would drop into lockout there. It stacks thermal, lockout and overvoltage faults to check priority. A wrong ordering would show the wrong code, or would assert gates-off together with low-side-on. It drives enable glitches of two and of three cycles: a debouncer that is off by one either lets the short glitch through or misses the longer one. It also checks that the overvoltage latch survives every input except reset.

// File: rtl/gfs_pkg.sv
package gfs_pkg;
  typedef enum logic [1:0] {
    FLT_NONE = 2'b00,
    FLT_UV   = 2'b01,
    FLT_HOT  = 2'b10,
    FLT_OV   = 2'b11
  } flt_code_e;

  // Highest-priority active fault wins
  function automatic flt_code_e encode_fault(logic ov, logic hot, logic uv);
    if (ov)       return FLT_OV;
    else if (hot) return FLT_HOT;
    else if (uv)  return FLT_UV;
    else          return FLT_NONE;
  endfunction

  // 2'b10 = all ones, 2'b01 = all zeros, 2'b00 = mixed
  function automatic logic [1:0] run_state(logic [7:0] hist, int unsigned len);
    logic ones;
    logic zeros;
    ones  = 1'b1;
    zeros = 1'b1;
    for (int i = 0; i < 8; i++) begin
      if (i < int'(len)) begin
        ones  = ones & hist[i];
        zeros = zeros & ~hist[i];
      end
    end
    return {ones, zeros};
  endfunction
endpackage

// File: rtl/gfs_flag_latch.sv
module gfs_flag_latch #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  // set dominates clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag_o <= RST_VAL;
    else if (set_i)  flag_o <= 1'b1;
    else if (clr_i)  flag_o <= 1'b0;
  end
endmodule

// File: rtl/gfs_en_filter.sv
module gfs_en_filter
  import gfs_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DEB_LEN     = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_in,
  output logic pin_high
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [DEB_LEN-1:0]     hist_q;
  logic [7:0]             hist_ext;
  logic [1:0]             run;

  always_comb begin
    hist_ext = '0;
    hist_ext[DEB_LEN-1:0] = hist_q;
    run = run_state(hist_ext, DEB_LEN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q   <= '1;
      hist_q   <= '1;
      pin_high <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_in};
      hist_q <= {hist_q[DEB_LEN-2:0], sync_q[SYNC_STAGES-1]};
      if (run[1])      pin_high <= 1'b1;
      else if (run[0]) pin_high <= 1'b0;
    end
  end
endmodule

// File: rtl/gate_fault_supervisor.sv
module gate_fault_supervisor
  import gfs_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DEB_LEN     = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vcc_start_ok,
  input  logic       vcc_hold_ok,
  input  logic       temp_trip,
  input  logic       temp_clear,
  input  logic       ss_armed,
  input  logic       sw_over,
  input  logic       en_sense,
  output logic       en_pull_low,
  output logic       gates_off,
  output logic       low_force_on,
  output logic [1:0] fault_code
);
  logic uv_act;
  logic hot_act;
  logic ov_act;
  logic en_ok;
  logic ext_disable;
  logic ov_event;

  assign ov_event = ss_armed & sw_over;

  gfs_flag_latch #(.RST_VAL(1'b1)) i_uv (
    .clk(clk), .rst_n(rst_n),
    .set_i(~vcc_hold_ok), .clr_i(vcc_start_ok), .flag_o(uv_act));

  gfs_flag_latch #(.RST_VAL(1'b0)) i_hot (
    .clk(clk), .rst_n(rst_n),
    .set_i(temp_trip), .clr_i(temp_clear), .flag_o(hot_act));

  gfs_flag_latch #(.RST_VAL(1'b0)) i_ov (
    .clk(clk), .rst_n(rst_n),
    .set_i(ov_event), .clr_i(1'b0), .flag_o(ov_act));

  gfs_en_filter #(.SYNC_STAGES(SYNC_STAGES), .DEB_LEN(DEB_LEN)) i_en (
    .clk(clk), .rst_n(rst_n), .pin_in(en_sense), .pin_high(en_ok));

  assign ext_disable  = ~en_ok;
  assign fault_code   = encode_fault(ov_act, hot_act, uv_act);
  assign en_pull_low  = uv_act | hot_act | ov_act;
  assign low_force_on = ov_act;
  assign gates_off    = (uv_act | hot_act | ext_disable) & ~ov_act;
endmodule

// File: rtl/gfs_supervisor_chk.sv
module gfs_supervisor_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       vcc_hold_ok,
  input logic       temp_trip,
  input logic       ss_armed,
  input logic       sw_over,
  input logic       en_pull_low,
  input logic       gates_off,
  input logic       low_force_on,
  input logic [1:0] fault_code,
  input logic       ext_disable,
  input logic       ov_act
);
  // R8
  excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(gates_off && low_force_on));
  // R5
  ov_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    low_force_on |=> low_force_on);
  // R5
  ov_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ss_armed && sw_over) |=> (fault_code == 2'b11));
  // R6
  pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_pull_low == (fault_code != 2'b00));
  // R4
  hot_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (temp_trip && !(ss_armed && sw_over) && !low_force_on) |=> (fault_code == 2'b10));
  // R3
  uv_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vcc_hold_ok |=> en_pull_low);
  // R9
  ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_disable && !ov_act) |-> gates_off);
endmodule

bind gate_fault_supervisor gfs_supervisor_chk i_chk (
  .clk(clk), .rst_n(rst_n), .vcc_hold_ok(vcc_hold_ok), .temp_trip(temp_trip),
  .ss_armed(ss_armed), .sw_over(sw_over), .en_pull_low(en_pull_low),
  .gates_off(gates_off), .low_force_on(low_force_on), .fault_code(fault_code),
  .ext_disable(ext_disable), .ov_act(ov_act));

// File: tb/test_gate_fault_supervisor.sv
`timescale 1ns/1ps
module test_gate_fault_supervisor;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vcc_start_ok = 1'b0, vcc_hold_ok = 1'b0, temp_trip = 1'b0, temp_clear = 1'b0;
  logic ss_armed = 1'b0, sw_over = 1'b0, en_sense = 1'b1;
  logic en_pull_low, gates_off, low_force_on;
  logic [1:0] fault_code;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic m_uv = 1'b1, m_hot = 1'b0, m_ov = 1'b0;
  logic last_pin = 1'b1;
  int stab = 0;

  always #2.5 clk = ~clk;

  gate_fault_supervisor i_gate_fault_supervisor (
    .clk(clk), .rst_n(rst_n), .vcc_start_ok(vcc_start_ok), .vcc_hold_ok(vcc_hold_ok),
    .temp_trip(temp_trip), .temp_clear(temp_clear), .ss_armed(ss_armed),
    .sw_over(sw_over), .en_sense(en_sense), .en_pull_low(en_pull_low),
    .gates_off(gates_off), .low_force_on(low_force_on), .fault_code(fault_code));

  function automatic logic [1:0] exp_code(logic ov, logic hot, logic uv);
    case ({ov, hot, uv}) inside
      3'b1??:  return 2'b11;
      3'b01?:  return 2'b10;
      3'b001:  return 2'b01;
      default: return 2'b00;
    endcase
  endfunction

  task automatic check(string req, logic [1:0] act, logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_update();
    if (!rst_n) begin
      m_uv = 1'b1; m_hot = 1'b0; m_ov = 1'b0; stab = 0;
    end else begin
      if (!vcc_hold_ok) m_uv = 1'b1;
      else if (vcc_start_ok) m_uv = 1'b0;
      if (temp_trip) m_hot = 1'b1;
      else if (temp_clear) m_hot = 1'b0;
      if (ss_armed && sw_over) m_ov = 1'b1;
      if (en_sense == last_pin) stab++;
      else stab = 0;
    end
    last_pin = en_sense;
  endtask

  task automatic step();
    @(posedge clk);
    #1 model_update();
    @(negedge clk);
  endtask

  task automatic check_model(string req);
    check({req, " code"}, fault_code, exp_code(m_ov, m_hot, m_uv));
    check({req, " pull"}, {1'b0, en_pull_low}, {1'b0, m_uv | m_hot | m_ov});
    check({req, " lfo"}, {1'b0, low_force_on}, {1'b0, m_ov});
    if (stab >= 8)
      check({req, " gates"}, {1'b0, gates_off},
            {1'b0, (m_uv | m_hot | ~en_sense) & ~m_ov});
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    #1 model_update();
    step(); step();
    rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit seen;
    void'($urandom(32'h1d5e_7a01));
    @(negedge clk);
    do_reset();
    // R1 reset state
    check("R1 code", fault_code, 2'b01);
    check("R1 pull", {1'b0, en_pull_low}, 2'b01);
    check("R1 gates", {1'b0, gates_off}, 2'b01);
    check("R1 lfo", {1'b0, low_force_on}, 2'b00);
    // R2 lockout holds without start flag
    vcc_hold_ok = 1'b1;
    for (int i = 0; i < 10; i++) step();
    check("R2 still locked", fault_code, 2'b01);
    vcc_start_ok = 1'b1; step();
    check("R2 released code", fault_code, 2'b00);
    check("R2 gates on", {1'b0, gates_off}, 2'b00);
    // R3 hysteresis window
    vcc_start_ok = 1'b0;
    for (int i = 0; i < 5; i++) step();
    check("R3 window no lock", fault_code, 2'b00);
    vcc_hold_ok = 1'b0; step();
    check("R3 relock", fault_code, 2'b01);
    check("R3 relock gates", {1'b0, gates_off}, 2'b01);
    vcc_hold_ok = 1'b1;
    for (int i = 0; i < 5; i++) step();
    check("R3 stays locked", fault_code, 2'b01);
    vcc_start_ok = 1'b1; step();
    check("R3 released", fault_code, 2'b00);
    // R4 thermal
    temp_trip = 1'b1; step(); temp_trip = 1'b0;
    check("R4 trip", fault_code, 2'b10);
    check("R4 gates", {1'b0, gates_off}, 2'b01);
    check("R6 pull thermal", {1'b0, en_pull_low}, 2'b01);
    for (int i = 0; i < 5; i++) step();
    check("R4 held", fault_code, 2'b10);
    temp_clear = 1'b1; step(); temp_clear = 1'b0;
    check("R4 cleared", fault_code, 2'b00);
    check("R6 pull none", {1'b0, en_pull_low}, 2'b00);
    // R5 single flags do not set overvoltage
    ss_armed = 1'b1; step(); ss_armed = 1'b0;
    sw_over = 1'b1; step(); sw_over = 1'b0;
    check("R5 single flag", {1'b0, low_force_on}, 2'b00);
    // R7 priority
    vcc_hold_ok = 1'b0; vcc_start_ok = 1'b0; temp_trip = 1'b1; step(); temp_trip = 1'b0;
    check("R7 hot over uv", fault_code, 2'b10);
    ss_armed = 1'b1; sw_over = 1'b1; step(); ss_armed = 1'b0; sw_over = 1'b0;
    check("R7 ov top", fault_code, 2'b11);
    check("R5 lfo", {1'b0, low_force_on}, 2'b01);
    check("R8 gates with ov", {1'b0, gates_off}, 2'b00);
    vcc_hold_ok = 1'b1; vcc_start_ok = 1'b1; temp_clear = 1'b1;
    for (int i = 0; i < 5; i++) step();
    temp_clear = 1'b0;
    check("R5 latched", fault_code, 2'b11);
    check("R5 latched lfo", {1'b0, low_force_on}, 2'b01);
    do_reset();
    check("R5 cleared by reset", fault_code, 2'b01);
    check("R5 lfo cleared", {1'b0, low_force_on}, 2'b00);
    step();
    for (int i = 0; i < 10; i++) step();
    check("R9 pre running", {1'b0, gates_off}, 2'b00);
    // R9 two-cycle glitch ignored
    en_sense = 1'b0; step(); step(); en_sense = 1'b1;
    seen = 0;
    for (int i = 0; i < 10; i++) begin step(); if (gates_off) seen = 1; end
    check("R9 short glitch", {1'b0, seen}, 2'b00);
    // R9 three-cycle low accepted, R10 no pull
    en_sense = 1'b0; step(); step(); step(); en_sense = 1'b1;
    seen = 0;
    for (int i = 0; i < 10; i++) begin
      step();
      if (gates_off) seen = 1;
      check("R10 pull", {1'b0, en_pull_low}, 2'b00);
    end
    check("R9 three low", {1'b0, seen}, 2'b01);
    check("R10 code", fault_code, 2'b00);
    en_sense = 1'b0;
    for (int i = 0; i < 6; i++) step();
    check("R9 held low", {1'b0, gates_off}, 2'b01);
    en_sense = 1'b1;
    for (int i = 0; i < 6; i++) step();
    check("R9 back high", {1'b0, gates_off}, 2'b00);
    // random phase, R1..R10 via model
    for (int n = 0; n < 4000; n++) begin
      if (n % 500 == 499) do_reset();
      check_model("R7 rand");
      vcc_hold_ok  = ($urandom % 20) != 0;
      vcc_start_ok = vcc_hold_ok && ($urandom % 4 == 0);
      temp_trip    = ($urandom % 40) == 0;
      temp_clear   = ($urandom % 8) == 0;
      ss_armed     = $urandom % 2;
      sw_over      = ($urandom % 150) == 0;
      if ($urandom % 25 == 0) en_sense = ~en_sense;
      step();
    end
    check_model("R8 final");
    if (!done) begin
      done = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule